// File: doc/BRIEF.md
# Device Reset and Mode Controller

This block is the top-level mode state machine of a flash-style memory device. It decides which read mode the device is in: normal array read, identification/query, secure region, configuration register access or secure region lock. It enters a special mode when a decoded entry command arrives while the device is in normal read. A software reset command is the only way to leave a special mode, and that command is refused while the embedded program/erase engine reports busy.

The active-low hardware reset pin is sampled through a synchronizer and must stay low for a minimum number of consecutive samples before it takes effect. A shorter dip is ignored. Once the reset qualifies, the block does four things. It returns the mode to normal read. It raises a global output tristate. It pulses clear strobes to the configuration register and to the upper address register. If the engine is busy, it sends the engine a one-cycle abort pulse. Commands are ignored for as long as the reset stays in effect. The tristate is released one clock after the reset ends.

Top module: `flash_mode_ctrl`

## Requirements
- R1: After `arst_n` is released, `mode` is 0, and `out_hiz`, `cfg_clr`, `uaddr_clr` and `eng_abort` are all low.
- R2: `rst_pin_n` passes through SYNC_STAGES register stages (default 2). A low run of MIN_PULSE consecutive samples (default 8) qualifies as a hardware reset. A shorter low run changes neither `mode` nor `out_hiz`.
- R3: `out_hiz` rises one clock after qualification. It stays high while the synchronized pin is low and for one clock after the first high sample, so a low run of L ≥ MIN_PULSE clocks gives L − MIN_PULSE + 2 cycles of `out_hiz`.
- R4: Each qualification produces exactly one single-cycle pulse on `cfg_clr` and on `uaddr_clr`, in the same cycle.
- R5: `eng_abort` pulses for exactly one cycle when `eng_busy` is high in the qualifying cycle, and stays low otherwise.
- R6: Qualification forces `mode` to 0 and overrides any command presented in the same cycle.
- R7: While the hardware reset is in effect, every command is ignored and `mode` stays 0.
- R8: `mode` encoding is 0 read, 1 ID/query, 2 secure region, 3 configuration register, 4 lock. Command codes 1 to 4 on `cmd_code` with `cmd_valid` move the mode from 0 to the equal value. Codes 0, 6 and 7 have no effect.
- R9: An entry command (codes 1 to 4) received in any mode other than 0 is ignored.
- R10: The software reset command (code 5) returns `mode` to 0 from any mode when `eng_busy` is low.
- R11: A software reset command received while `eng_busy` is high is ignored, and the mode is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_pin_n | input | 1 | Hardware reset pin, active low, asynchronous to clk |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_code | input | 3 | Decoded command: 1-4 enter mode, 5 software reset |
| eng_busy | input | 1 | Program/erase engine busy |
| mode | output | 3 | Current device mode |
| out_hiz | output | 1 | Global output tristate request |
| cfg_clr | output | 1 | Configuration register restore strobe |
| uaddr_clr | output | 1 | Upper address register clear strobe |
| eng_abort | output | 1 | Single-cycle abort to the program/erase engine |

## Verification
Two events can land on the same clock edge: hardware reset qualification and a decoded command, either a mode entry or a software reset. A directed case holds an entry command valid for every cycle of a long low pulse. The command is therefore taken before qualification, lands exactly on the qualifying edge, and is then refused while the reset is in effect. The mode must end at 0. The random phase mixes low runs of varying length, including runs just under and just over MIN_PULSE, with random commands and busy toggles. A bench-side model derived from the requirements judges `mode`, `out_hiz`, the clear strobes and the abort pulse on every cycle.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

   typedef enum logic [2:0] {
      MODE_READ   = 3'd0,
      MODE_IDCFI  = 3'd1,
      MODE_SECURE = 3'd2,
      MODE_CFGREG = 3'd3,
      MODE_LOCK   = 3'd4
   } mode_e;

   localparam logic [2:0] CMD_SOFT_RST = 3'd5;

   function automatic logic is_entry(input logic [2:0] code);
      return (code >= 3'd1) && (code <= 3'd4);
   endfunction

endpackage

// File: rtl/fmc_pin_sync.sv
module fmc_pin_sync #(
   parameter int   STAGES  = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_in,
   output logic pin_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fmc_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain_q[i] <= IDLE_LVL;
            else         chain_q[i] <= pin_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain_q[i] <= IDLE_LVL;
            else         chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign pin_out = chain_q[STAGES-1];

endmodule

// File: rtl/fmc_pulse_qual.sv
module fmc_pulse_qual #(
   parameter int MIN_PULSE = 8
) (
   input  logic clk,
   input  logic arst_n,
   input  logic pin_s,
   input  logic eng_busy,
   output logic hit,
   output logic active,
   output logic hiz,
   output logic clr_pulse,
   output logic abort_pulse
);

   if (MIN_PULSE < 1) begin : g_bad_min
      $error("fmc_pulse_qual: MIN_PULSE must be at least 1");
   end

   localparam int CW = $clog2(MIN_PULSE + 1);
   localparam logic [CW-1:0] RUN_LAST = CW'(MIN_PULSE - 1);
   localparam logic [CW-1:0] RUN_SAT  = CW'(MIN_PULSE);

   logic [CW-1:0] run_q;
   logic          active_q;
   logic          hiz_q;
   logic          clr_q;
   logic          abort_q;

   assign hit = !pin_s && (run_q == RUN_LAST) && !active_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         run_q    <= '0;
         active_q <= 1'b0;
         hiz_q    <= 1'b0;
         clr_q    <= 1'b0;
         abort_q  <= 1'b0;
      end else begin
         if (pin_s)
            run_q <= '0;
         else if (run_q != RUN_SAT)
            run_q <= run_q + 1'b1;

         if (hit)
            active_q <= 1'b1;
         else if (pin_s)
            active_q <= 1'b0;

         hiz_q   <= hit | active_q;
         clr_q   <= hit;
         abort_q <= hit & eng_busy;
      end
   end

   assign active      = active_q;
   assign hiz         = hiz_q;
   assign clr_pulse   = clr_q;
   assign abort_pulse = abort_q;

endmodule

// File: rtl/fmc_mode_fsm.sv
module fmc_mode_fsm
   import fmc_pkg::*;
(
   input  logic       clk,
   input  logic       arst_n,
   input  logic       hw_hit,
   input  logic       hw_active,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_code,
   input  logic       eng_busy,
   output mode_e      mode
);

   mode_e mode_q;
   mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      if (hw_hit) begin
         mode_d = MODE_READ;
      end else if (!hw_active && cmd_valid) begin
         if (cmd_code == CMD_SOFT_RST) begin
            if (!eng_busy) mode_d = MODE_READ;
         end else if (is_entry(cmd_code) && (mode_q == MODE_READ)) begin
            mode_d = mode_e'(cmd_code);
         end
      end
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) mode_q <= MODE_READ;
      else         mode_q <= mode_d;
   end

   assign mode = mode_q;

endmodule

// File: rtl/flash_mode_ctrl.sv
module flash_mode_ctrl
   import fmc_pkg::*;
#(
   parameter int MIN_PULSE   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       arst_n,
   input  logic       rst_pin_n,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_code,
   input  logic       eng_busy,
   output logic [2:0] mode,
   output logic       out_hiz,
   output logic       cfg_clr,
   output logic       uaddr_clr,
   output logic       eng_abort
);

   logic  pin_s;
   logic  hw_hit;
   logic  hw_active;
   logic  clr_pulse;
   mode_e mode_cur;

   fmc_pin_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_LVL (1'b1)
   ) u_sync (
      .clk     (clk),
      .arst_n  (arst_n),
      .pin_in  (rst_pin_n),
      .pin_out (pin_s)
   );

   fmc_pulse_qual #(
      .MIN_PULSE (MIN_PULSE)
   ) u_qual (
      .clk         (clk),
      .arst_n      (arst_n),
      .pin_s       (pin_s),
      .eng_busy    (eng_busy),
      .hit         (hw_hit),
      .active      (hw_active),
      .hiz         (out_hiz),
      .clr_pulse   (clr_pulse),
      .abort_pulse (eng_abort)
   );

   fmc_mode_fsm u_fsm (
      .clk       (clk),
      .arst_n    (arst_n),
      .hw_hit    (hw_hit),
      .hw_active (hw_active),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .eng_busy  (eng_busy),
      .mode      (mode_cur)
   );

   assign mode      = mode_cur;
   assign cfg_clr   = clr_pulse;
   assign uaddr_clr = clr_pulse;

endmodule

// File: rtl/fmc_chk.sv
module fmc_chk (
   input logic       clk,
   input logic       arst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_code,
   input logic       eng_busy,
   input logic [2:0] mode,
   input logic       out_hiz,
   input logic       cfg_clr,
   input logic       uaddr_clr,
   input logic       eng_abort,
   input logic       hw_hit,
   input logic       hw_active
);

   // R5
   abort_needs_busy_chk: assert property (@(posedge clk) disable iff (!arst_n)
      eng_abort |-> $past(eng_busy));

   // R5
   abort_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
      eng_abort |=> !eng_abort);

   // R4
   clr_pair_chk: assert property (@(posedge clk) disable iff (!arst_n)
      cfg_clr |-> (uaddr_clr && out_hiz && mode == 3'd0));

   // R6
   hit_to_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
      hw_hit |=> (mode == 3'd0));

   // R7
   active_idle_chk: assert property (@(posedge clk) disable iff (!arst_n)
      hw_active |-> (mode == 3'd0));

   // R3
   hiz_tail_chk: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(hw_active) |-> out_hiz);

   // R11
   soft_busy_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (cmd_valid && cmd_code == 3'd5 && eng_busy && !hw_hit && !hw_active)
      |=> $stable(mode));

   // R9
   entry_nonidle_chk: assert property (@(posedge clk) disable iff (!arst_n)
      (cmd_valid && cmd_code >= 3'd1 && cmd_code <= 3'd4 && mode != 3'd0 && !hw_hit)
      |=> $stable(mode));

   // R8
   mode_legal_chk: assert property (@(posedge clk) disable iff (!arst_n)
      mode <= 3'd4);

endmodule

bind flash_mode_ctrl fmc_chk u_chk (
   .clk       (clk),
   .arst_n    (arst_n),
   .cmd_valid (cmd_valid),
   .cmd_code  (cmd_code),
   .eng_busy  (eng_busy),
   .mode      (mode),
   .out_hiz   (out_hiz),
   .cfg_clr   (cfg_clr),
   .uaddr_clr (uaddr_clr),
   .eng_abort (eng_abort),
   .hw_hit    (hw_hit),
   .hw_active (hw_active)
);

// File: tb/flash_mode_ctrl_test.sv
`timescale 1ns/1ps
module flash_mode_ctrl_test;

   localparam int MIN = 8;

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       rst_pin_n = 1'b1;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_code = 3'd0;
   logic       eng_busy = 1'b0;
   logic [2:0] mode;
   logic       out_hiz, cfg_clr, uaddr_clr, eng_abort;

   int total = 0;
   int bad   = 0;

   // reference model state
   logic   m_sh1 = 1'b1, m_s = 1'b1, m_inr = 1'b0, m_hz = 1'b0;
   logic   m_clr = 1'b0, m_abort = 1'b0;
   int     m_run = 0;
   logic [2:0] m_mode = 3'd0;

   int hz_cnt = 0, clr_cnt = 0, abort_cnt = 0;

   always #4 clk = ~clk;

   flash_mode_ctrl #(.MIN_PULSE(MIN), .SYNC_STAGES(2)) uut (
      .clk(clk), .arst_n(arst_n), .rst_pin_n(rst_pin_n),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .eng_busy(eng_busy),
      .mode(mode), .out_hiz(out_hiz), .cfg_clr(cfg_clr),
      .uaddr_clr(uaddr_clr), .eng_abort(eng_abort)
   );

   function automatic logic [2:0] exp_mode(input logic [2:0] cur, input logic hit,
                                           input logic inr, input logic cv,
                                           input logic [2:0] code, input logic busy);
      if (hit) return 3'd0;
      if (inr || !cv) return cur;
      if (code == 3'd5) return busy ? cur : 3'd0;
      if (code >= 3'd1 && code <= 3'd4 && cur == 3'd0) return code;
      return cur;
   endfunction

   function automatic int exp_hiz_len(input int low_len);
      return (low_len >= MIN) ? (low_len - MIN + 2) : 0;
   endfunction

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      logic hit;
      @(posedge clk);
      if (!arst_n) begin
         m_sh1 = 1'b1; m_s = 1'b1; m_inr = 1'b0; m_hz = 1'b0;
         m_clr = 1'b0; m_abort = 1'b0; m_run = 0; m_mode = 3'd0;
      end else begin
         hit     = !m_s && (m_run == MIN - 1) && !m_inr;
         m_mode  = exp_mode(m_mode, hit, m_inr, cmd_valid, cmd_code, eng_busy);
         m_abort = hit && eng_busy;
         m_clr   = hit;
         m_hz    = hit || m_inr;
         if (hit) m_inr = 1'b1;
         else if (m_s) m_inr = 1'b0;
         if (m_s) m_run = 0;
         else if (m_run < MIN) m_run = m_run + 1;
         m_s   = m_sh1;
         m_sh1 = rst_pin_n;
      end
      @(negedge clk);
      if (out_hiz)   hz_cnt++;
      if (cfg_clr)   clr_cnt++;
      if (eng_abort) abort_cnt++;
      check(mode == m_mode, "R8 model mode", mode, m_mode);
      check(out_hiz == m_hz, "R3 model out_hiz", out_hiz, m_hz);
      check(cfg_clr == m_clr && uaddr_clr == m_clr, "R4 model clears",
            {cfg_clr, uaddr_clr}, {m_clr, m_clr});
      check(eng_abort == m_abort, "R5 model abort", eng_abort, m_abort);
   endtask

   task automatic do_cmd(input logic [2:0] code);
      cmd_valid = 1'b1;
      cmd_code  = code;
      step();
      cmd_valid = 1'b0;
      cmd_code  = 3'd0;
   endtask

   task automatic clear_counts();
      hz_cnt = 0; clr_cnt = 0; abort_cnt = 0;
   endtask

   task automatic pulse(input int len);
      rst_pin_n = 1'b0;
      repeat (len) step();
      rst_pin_n = 1'b1;
      repeat (6) step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed_init;
      int seg_left;
      logic seg_low;
      seed_init = $urandom(32'd2024);

      repeat (3) step();
      arst_n = 1'b1;
      step();
      // R1 reset state
      check(mode == 3'd0, "R1 mode", mode, 0);
      check(!out_hiz && !cfg_clr && !uaddr_clr && !eng_abort, "R1 strobes",
            {out_hiz, cfg_clr, uaddr_clr, eng_abort}, 0);

      // R8 entry, R9 entry refused, R10 soft exit
      do_cmd(3'd1);
      check(mode == 3'd1, "R8 enter id", mode, 1);
      do_cmd(3'd2);
      check(mode == 3'd1, "R9 entry in id ignored", mode, 1);
      do_cmd(3'd6);
      check(mode == 3'd1, "R8 unused code ignored", mode, 1);
      do_cmd(3'd5);
      check(mode == 3'd0, "R10 soft reset from id", mode, 0);

      // R11 soft reset refused while busy
      do_cmd(3'd3);
      check(mode == 3'd3, "R8 enter cfg", mode, 3);
      eng_busy = 1'b1;
      do_cmd(3'd5);
      check(mode == 3'd3, "R11 soft reset while busy", mode, 3);
      eng_busy = 1'b0;
      do_cmd(3'd5);
      check(mode == 3'd0, "R10 soft reset after busy", mode, 0);

      // R2 short pulse ignored
      do_cmd(3'd4);
      clear_counts();
      pulse(MIN - 1);
      check(mode == 3'd4, "R2 short pulse keeps mode", mode, 4);
      check(hz_cnt == 0, "R2 short pulse no hiz", hz_cnt, 0);
      do_cmd(3'd5);

      // R3 R4 R5 R6 full pulse with busy engine
      do_cmd(3'd2);
      eng_busy = 1'b1;
      clear_counts();
      pulse(MIN + 3);
      eng_busy = 1'b0;
      check(mode == 3'd0, "R6 qualified pulse to idle", mode, 0);
      check(hz_cnt == exp_hiz_len(MIN + 3), "R3 hiz length", hz_cnt, exp_hiz_len(MIN + 3));
      check(clr_cnt == 1, "R4 one clear pulse", clr_cnt, 1);
      check(abort_cnt == 1, "R5 one abort pulse", abort_cnt, 1);

      // R5 no abort when idle engine; R3 minimum length pulse
      clear_counts();
      pulse(MIN);
      check(abort_cnt == 0, "R5 no abort when idle", abort_cnt, 0);
      check(hz_cnt == exp_hiz_len(MIN), "R3 hiz at minimum", hz_cnt, exp_hiz_len(MIN));

      // R6 R7 command held through the whole pulse
      rst_pin_n = 1'b0;
      cmd_valid = 1'b1;
      cmd_code  = 3'd1;
      step();
      check(mode == 3'd1, "R8 entry before qualification", mode, 1);
      repeat (MIN + 3) step();
      check(mode == 3'd0, "R7 commands ignored in reset", mode, 0);
      rst_pin_n = 1'b1;
      cmd_valid = 1'b0;
      cmd_code  = 3'd0;
      repeat (6) step();
      check(mode == 3'd0, "R7 mode idle after reset", mode, 0);

      // random phase
      seg_left = 0;
      seg_low  = 1'b0;
      for (int i = 0; i < 4000; i++) begin
         if (seg_left == 0) begin
            seg_low  = !seg_low && ($urandom_range(0, 2) == 0);
            seg_left = seg_low ? $urandom_range(MIN - 2, MIN + 4) : $urandom_range(1, 12);
         end
         seg_left--;
         rst_pin_n = !seg_low;
         cmd_valid = ($urandom_range(0, 2) == 0);
         cmd_code  = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 15) == 0) eng_busy = !eng_busy;
         step();
      end
      rst_pin_n = 1'b1;
      cmd_valid = 1'b0;
      repeat (6) step();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule